// File: doc/BRIEF.md
# Downward Stack Pointer Register

This block holds the stack address of a small 8-bit processor core whose stack fills from high addresses toward low ones. The core's sequencer raises one strobe per cycle. A data-byte push or pop moves the pointer by one, and a call or return moves it by two. The memory side reads the current pointer and an access address that tells it where the byte being pushed or popped lives.

Software reaches the pointer through a byte-wide register port that selects either the low byte or the bits above it. A write to one byte leaves the other byte as it was. Reset loads the highest address of internal SRAM. A narrow build with an 8-bit pointer has no upper register at all.

If two or more operations arrive in the same cycle, the pointer keeps its value and a one-cycle error pulse follows.

Top module: `stkptr_unit`

## Requirements
- R1: While reset is low, and on the first cycle after it, the pointer equals the parameter TOP_ADDR and the error flag is 0.
- R2: A lone push strobe lowers the pointer by 1 at the next clock edge (post-decrement). In the cycle of the strobe, the access address equals the pointer.
- R3: A lone pop strobe raises the pointer by 1 at the next edge. In the cycle of the strobe, the access address equals the pointer plus 1.
- R4: A lone call strobe lowers the pointer by 2. In the cycle of the strobe, the access address equals the pointer.
- R5: A lone return strobe raises the pointer by 2. In the cycle of the strobe, the access address equals the pointer plus 1.
- R6: Pointer arithmetic wraps modulo 2^ADDR_W, so 0 minus 1 gives all ones and all ones plus 1 gives 0.
- R7: When two or more of push, pop, call, return and register write are high in one cycle, the pointer is unchanged and the error flag is 1 for exactly the following cycle. In the clash cycle the access address equals the pointer.
- R8: A lone register write with select 0 puts the write data into pointer bits 7:0 and keeps the bits above 7.
- R9: A lone register write with select 1 puts write data bits [ADDR_W-9:0] into pointer bits above 7, drops the remaining data bits, and keeps bits 7:0.
- R10: Read data is combinational: select 0 returns pointer bits 7:0, and select 1 returns the bits above 7, zero-extended to 8 bits.
- R11: With ADDR_W = 8 there is no upper register: select 1 reads 0, and a write with select 1 leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Data byte push strobe |
| pop_i | input | 1 | Data byte pop strobe |
| call_i | input | 1 | Call or interrupt entry strobe |
| ret_i | input | 1 | Return strobe |
| reg_sel_i | input | 1 | Byte select: 0 low byte, 1 upper bits |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data of the selected byte |
| sp_o | output | ADDR_W | Current stack pointer |
| acc_addr_o | output | ADDR_W | Memory address of the current push or pop access |
| clash_o | output | 1 | One-cycle pulse after a multi-operation cycle |

## Verification
The hardest cases to reach are the wrap points at zero and at all ones, because the pointer starts near the top of SRAM. A long run of pops or pushes would be needed to get there. The stimulus avoids this by writing both byte registers to steer the pointer to 0 or 1, then issuing a push or a call across the boundary. A second instance built with an 8-bit pointer shares the same stimulus, so every upper-byte write also tests that the narrow build ignores it.

// File: rtl/stkptr_pkg.sv
`timescale 1ns/1ps
package stkptr_pkg;

   typedef enum logic [2:0] {
      SP_IDLE,
      SP_PUSH,
      SP_POP,
      SP_CALL,
      SP_RET,
      SP_WRLO,
      SP_WRHI
   } sp_op_e;

   localparam int unsigned DATA_STEP  = 1;
   localparam int unsigned RADDR_STEP = 2;
   localparam int unsigned BYTE_W     = 8;

endpackage

// File: rtl/stkptr_opdec.sv
`timescale 1ns/1ps
module stkptr_opdec
   import stkptr_pkg::*;
(
   input  logic   push_i,
   input  logic   pop_i,
   input  logic   call_i,
   input  logic   ret_i,
   input  logic   wr_i,
   input  logic   sel_i,
   output sp_op_e op_o,
   output logic   clash_o
);

   logic [2:0] n_req;

   always_comb begin
      n_req   = 3'(push_i) + 3'(pop_i) + 3'(call_i) + 3'(ret_i) + 3'(wr_i);
      clash_o = (n_req > 3'd1);
      op_o    = SP_IDLE;
      if (!clash_o) begin
         if (push_i)      op_o = SP_PUSH;
         else if (pop_i)  op_o = SP_POP;
         else if (call_i) op_o = SP_CALL;
         else if (ret_i)  op_o = SP_RET;
         else if (wr_i)   op_o = sel_i ? SP_WRHI : SP_WRLO;
      end
   end

endmodule

// File: rtl/stkptr_step.sv
`timescale 1ns/1ps
module stkptr_step
   import stkptr_pkg::*;
#(
   parameter int unsigned W = 10
) (
   input  logic [W-1:0] cur_i,
   input  sp_op_e       op_i,
   input  logic [7:0]   wdata_i,
   output logic [W-1:0] nxt_o,
   output logic [W-1:0] acc_o
);

   localparam logic [W-1:0] DSTEP = W'(DATA_STEP);
   localparam logic [W-1:0] RSTEP = W'(RADDR_STEP);

   logic [W-1:0] lo_wr;
   logic [W-1:0] hi_wr;

   generate
      if (W > BYTE_W) begin : g_two_byte
         assign lo_wr = {cur_i[W-1:BYTE_W], wdata_i};
         assign hi_wr = {wdata_i[W-BYTE_W-1:0], cur_i[BYTE_W-1:0]};
      end else begin : g_one_byte
         assign lo_wr = wdata_i;
         assign hi_wr = cur_i;
      end
   endgenerate

   always_comb begin
      nxt_o = cur_i;
      acc_o = cur_i;
      case (op_i)
         SP_PUSH: nxt_o = cur_i - DSTEP;
         SP_POP: begin
            nxt_o = cur_i + DSTEP;
            acc_o = cur_i + DSTEP;
         end
         SP_CALL: nxt_o = cur_i - RSTEP;
         SP_RET: begin
            nxt_o = cur_i + RSTEP;
            acc_o = cur_i + DSTEP;
         end
         SP_WRLO: nxt_o = lo_wr;
         SP_WRHI: nxt_o = hi_wr;
         default: nxt_o = cur_i;
      endcase
   end

endmodule

// File: rtl/stkptr_rdmux.sv
`timescale 1ns/1ps
module stkptr_rdmux #(
   parameter int unsigned W = 10
) (
   input  logic [W-1:0] sp_i,
   input  logic         sel_i,
   output logic [7:0]   rdata_o
);

   logic [7:0] hi_byte;

   generate
      if (W > 8) begin : g_hi
         logic [15:0] ext;
         assign ext     = 16'(sp_i);
         assign hi_byte = ext[15:8];
      end else begin : g_no_hi
         assign hi_byte = 8'h00;
      end
   endgenerate

   assign rdata_o = sel_i ? hi_byte : sp_i[7:0];

endmodule

// File: rtl/stkptr_unit.sv
`timescale 1ns/1ps
module stkptr_unit
   import stkptr_pkg::*;
#(
   parameter int unsigned ADDR_W   = 10,
   parameter int unsigned TOP_ADDR = 'h2FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_i,
   input  logic              pop_i,
   input  logic              call_i,
   input  logic              ret_i,
   input  logic              reg_sel_i,
   input  logic              reg_wr_i,
   input  logic [7:0]        reg_wdata_i,
   output logic [7:0]        reg_rdata_o,
   output logic [ADDR_W-1:0] sp_o,
   output logic [ADDR_W-1:0] acc_addr_o,
   output logic              clash_o
);

   localparam logic [ADDR_W-1:0] RST_SP = ADDR_W'(TOP_ADDR);
   localparam logic [ADDR_W-1:0] ONE    = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] TWO    = ADDR_W'(2);

   generate
      if (ADDR_W < 8 || ADDR_W > 16) begin : g_bad_width
         $error("stkptr_unit: ADDR_W must lie in 8..16");
      end
      if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_top
         $error("stkptr_unit: TOP_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   sp_op_e            op;
   logic              clash;
   logic [ADDR_W-1:0] sp_q;
   logic [ADDR_W-1:0] sp_nxt;
   logic              clash_q;

   stkptr_opdec u_dec (
      .push_i (push_i),
      .pop_i  (pop_i),
      .call_i (call_i),
      .ret_i  (ret_i),
      .wr_i   (reg_wr_i),
      .sel_i  (reg_sel_i),
      .op_o   (op),
      .clash_o(clash)
   );

   stkptr_step #(.W(ADDR_W)) u_step (
      .cur_i  (sp_q),
      .op_i   (op),
      .wdata_i(reg_wdata_i),
      .nxt_o  (sp_nxt),
      .acc_o  (acc_addr_o)
   );

   stkptr_rdmux #(.W(ADDR_W)) u_rd (
      .sp_i   (sp_q),
      .sel_i  (reg_sel_i),
      .rdata_o(reg_rdata_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q    <= RST_SP;
         clash_q <= 1'b0;
      end else begin
         if (!clash) sp_q <= sp_nxt;
         clash_q <= clash;
      end
   end

   assign sp_o    = sp_q;
   assign clash_o = clash_q;

   logic only_push, only_pop, only_call, only_ret, only_wr, multi;
   assign only_push = push_i & ~pop_i & ~call_i & ~ret_i & ~reg_wr_i;
   assign only_pop  = ~push_i & pop_i & ~call_i & ~ret_i & ~reg_wr_i;
   assign only_call = ~push_i & ~pop_i & call_i & ~ret_i & ~reg_wr_i;
   assign only_ret  = ~push_i & ~pop_i & ~call_i & ret_i & ~reg_wr_i;
   assign only_wr   = ~push_i & ~pop_i & ~call_i & ~ret_i & reg_wr_i;
   assign multi     = $countones({push_i, pop_i, call_i, ret_i, reg_wr_i}) > 1;

   AST_RESET_TOP: assert property (@(posedge clk)
      !rst_n |=> (sp_o == RST_SP && !clash_o)); // R1
   AST_PUSH_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      only_push |=> sp_o == $past(sp_o) - ONE); // R2
   AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      only_push |-> acc_addr_o == sp_o); // R2
   AST_POP_INC: assert property (@(posedge clk) disable iff (!rst_n)
      only_pop |=> sp_o == $past(sp_o) + ONE); // R3
   AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      only_pop |-> acc_addr_o == sp_o + ONE); // R3
   AST_CALL_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      only_call |=> sp_o == $past(sp_o) - TWO); // R4
   AST_RET_INC: assert property (@(posedge clk) disable iff (!rst_n)
      only_ret |=> sp_o == $past(sp_o) + TWO); // R5
   AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      multi |=> clash_o); // R7
   AST_CLASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      clash_o |-> sp_o == $past(sp_o)); // R7

   generate
      if (ADDR_W > 8) begin : g_chk_two
         AST_LO_KEEPS_HI: assert property (@(posedge clk) disable iff (!rst_n)
            (only_wr && !reg_sel_i) |=> sp_o[ADDR_W-1:8] == $past(sp_o[ADDR_W-1:8])); // R8
         AST_HI_KEEPS_LO: assert property (@(posedge clk) disable iff (!rst_n)
            (only_wr && reg_sel_i) |=> sp_o[7:0] == $past(sp_o[7:0])); // R9
      end else begin : g_chk_one
         AST_NO_HI_REG: assert property (@(posedge clk) disable iff (!rst_n)
            (only_wr && reg_sel_i) |=> $stable(sp_o)); // R11
      end
   endgenerate

endmodule

// File: tb/stkptr_unit_tb.sv
`timescale 1ns/1ps
module stkptr_unit_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       push_i = 0, pop_i = 0, call_i = 0, ret_i = 0;
   logic       reg_sel_i = 0, reg_wr_i = 0;
   logic [7:0] reg_wdata_i = 8'h00;
   logic [7:0] rd_big, rd_small;
   logic [9:0] sp_big, acc_big;
   logic [7:0] sp_small, acc_small;
   logic       clash_big, clash_small;

   always #4 clk = ~clk;

   stkptr_unit #(.ADDR_W(10), .TOP_ADDR('h2FF)) u_dut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .call_i(call_i), .ret_i(ret_i), .reg_sel_i(reg_sel_i),
      .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(rd_big), .sp_o(sp_big), .acc_addr_o(acc_big),
      .clash_o(clash_big));

   stkptr_unit #(.ADDR_W(8), .TOP_ADDR('hFF)) u_small (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .call_i(call_i), .ret_i(ret_i), .reg_sel_i(reg_sel_i),
      .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(rd_small), .sp_o(sp_small), .acc_addr_o(acc_small),
      .clash_o(clash_small));

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;
   int m_big = 'h2FF;
   int m_small = 'hFF;

   int    q_big[$], q_small[$], q_err[$];
   string q_tag[$];

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int model_nxt(int cur, int w, bit pu, bit po, bit ca,
                                    bit re, bit wr, bit sel, int d);
      int m = (1 << w) - 1;
      if (int'(pu) + int'(po) + int'(ca) + int'(re) + int'(wr) > 1) return cur;
      if (pu) return (cur - 1) & m;
      if (po) return (cur + 1) & m;
      if (ca) return (cur - 2) & m;
      if (re) return (cur + 2) & m;
      if (wr && !sel) return (cur & m & ~255) | d;
      if (wr && sel) return (w > 8) ? (((d << 8) & m) | (cur & 255)) : cur;
      return cur;
   endfunction

   function automatic int model_acc(int cur, int w, bit pu, bit po, bit ca,
                                    bit re, bit wr);
      int m = (1 << w) - 1;
      if (int'(pu) + int'(po) + int'(ca) + int'(re) + int'(wr) > 1) return cur;
      if (po || re) return (cur + 1) & m;
      return cur;
   endfunction

   // driver: applies one cycle of stimulus, checks combinational outputs,
   // queues the registered result expected after the next edge
   task automatic apply(input bit pu, input bit po, input bit ca, input bit re,
                        input bit wr, input bit sel, input int d, input string tag);
      bit clash;
      @(negedge clk);
      push_i = pu; pop_i = po; call_i = ca; ret_i = re;
      reg_wr_i = wr; reg_sel_i = sel; reg_wdata_i = 8'(d);
      #1;
      clash = (int'(pu) + int'(po) + int'(ca) + int'(re) + int'(wr)) > 1;
      check({tag, " acc big"}, int'(acc_big), model_acc(m_big, 10, pu, po, ca, re, wr));
      check({tag, " acc small"}, int'(acc_small), model_acc(m_small, 8, pu, po, ca, re, wr));
      m_big   = model_nxt(m_big, 10, pu, po, ca, re, wr, sel, d);
      m_small = model_nxt(m_small, 8, pu, po, ca, re, wr, sel, d);
      q_big.push_back(m_big);
      q_small.push_back(m_small);
      q_err.push_back(int'(clash));
      q_tag.push_back(tag);
   endtask

   task automatic rd(input bit sel, input string tag);
      apply(0, 0, 0, 0, 0, sel, 0, tag);
      check({tag, " rdata big"}, int'(rd_big), sel ? (m_big >> 8) : (m_big & 255));
      check({tag, " rdata small"}, int'(rd_small), sel ? 0 : (m_small & 255));
   endtask

   // monitor: compares registered outputs after each edge
   always @(posedge clk) begin
      #1;
      if (q_big.size() > 0) begin
         int eb, es, ee;
         string t;
         eb = q_big.pop_front();
         es = q_small.pop_front();
         ee = q_err.pop_front();
         t  = q_tag.pop_front();
         check({t, " sp big"}, int'(sp_big), eb);
         check({t, " sp small"}, int'(sp_small), es);
         check({t, " clash big"}, int'(clash_big), ee);
         check({t, " clash small"}, int'(clash_small), ee);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset sp big", int'(sp_big), 'h2FF);
      check("R1 reset sp small", int'(sp_small), 'hFF);
      check("R1 reset clash", int'(clash_big), 0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 first cycle sp big", int'(sp_big), 'h2FF);

      apply(1, 0, 0, 0, 0, 0, 0, "R2 push");
      apply(1, 0, 0, 0, 0, 0, 0, "R2 push again");
      apply(0, 1, 0, 0, 0, 0, 0, "R3 pop");
      apply(0, 0, 1, 0, 0, 0, 0, "R4 call");
      apply(0, 0, 0, 1, 0, 0, 0, "R5 ret");
      rd(0, "R10 read low");
      rd(1, "R10 read high");
      apply(0, 0, 0, 0, 1, 0, 'h05, "R8 write low");
      rd(1, "R8 high kept");
      apply(0, 0, 0, 0, 1, 1, 'hFD, "R9 R11 write high");
      rd(0, "R9 low kept");
      rd(1, "R11 high read");
      apply(0, 0, 0, 0, 1, 1, 'h00, "R6 steer high");
      apply(0, 0, 0, 0, 1, 0, 'h00, "R6 steer low");
      apply(1, 0, 0, 0, 0, 0, 0, "R6 push below zero");
      apply(0, 1, 0, 0, 0, 0, 0, "R6 pop past top");
      apply(0, 0, 0, 0, 1, 0, 'h01, "R6 set one");
      apply(0, 0, 1, 0, 0, 0, 0, "R6 call wrap");
      apply(0, 0, 0, 1, 0, 0, 0, "R6 ret wrap");
      apply(1, 1, 0, 0, 0, 0, 0, "R7 push pop clash");
      apply(0, 0, 0, 0, 0, 0, 0, "R7 flag drops");
      apply(0, 0, 1, 0, 1, 1, 'h3C, "R7 call write clash");
      apply(1, 0, 1, 1, 0, 0, 0, "R7 triple clash");
      apply(0, 0, 0, 1, 0, 0, 0, "R5 ret after clash");
      apply(0, 0, 0, 0, 0, 0, 0, "idle");
      repeat (2) @(posedge clk);
      #2;
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule